// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the raster timing for a parallel RGB display panel from a pixel clock. Software programs the visible area, the full line and frame lengths, the porch positions and the sync pulse widths through a small word-addressed register port. The block then runs a horizontal and a vertical pixel counter and drives horizontal sync, vertical sync, a data-enable strobe and the current pixel coordinates. It also raises a vertical-blank interrupt through a sticky status bit that software acknowledges.

Each line runs active pixels first, then front porch, then the sync pulse, then back porch. The vertical axis follows the same order in whole lines. Both back-porch fields are measured from the start of the sync pulse to the end of the line or frame, so each one includes the sync width. The front porch is whatever remains: total minus active minus back porch. Timing fields written while the block runs are staged and only take effect when the frame wraps, so a frame is never split between two settings. Sync polarity, the enables, the pin tristate mask and the interrupt controls act at once. The pins start out in high impedance and software must clear the mask to drive them.

Register map (word address, fields at bits [11:0] "lo" and [27:16] "hi"): 0 control (bit0 global enable, bit1 channel enable); 1 size (lo active width, hi active height); 2 line timing (lo total pixels, hi back porch); 3 frame timing (lo total lines, hi back porch); 4 sync widths (lo horizontal, hi vertical); 5 polarity; 6 tristate mask; 7 interrupt.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the tristate mask reads 3'b111 and all three output enables are low. The control word reads 0. The interrupt output is low and both pixel counters are 0.
- R2: `reg_rdata` combinationally returns the register at `reg_addr`. For addresses 1 to 4 this is the staged value most recently written, with lo in bits [11:0] and hi in bits [27:16]. Address 6 returns the mask in bits [2:0]. Address 7 returns the interrupt enable in bit 0 and the status in bit 1.
- R3: The timing runs only while control bits 0 and 1 are both 1. Otherwise both counters are held at 0, data-enable is low and both syncs sit at their deasserted level.
- R4: While running, `pix_x` counts 0 to total pixels minus 1 and then wraps to 0. `pix_y` advances on each wrap and runs from 0 to total lines minus 1.
- R5: The horizontal sync is asserted for `pix_x` in [total − back porch, total − back porch + horizontal width).
- R6: The vertical sync is asserted for `pix_y` in [total lines − vertical back porch, that value + vertical width).
- R7: Polarity bit 0 (horizontal) and bit 1 (vertical) select the asserted level: 1 means asserted high, 0 means asserted low.
- R8: `de_o` is high only while running with `pix_x` below the active width and `pix_y` below the active height.
- R9: Tristate mask bit 0 (hsync), bit 1 (vsync) and bit 2 (data-enable) each drive the matching output enable low when set.
- R10: The vblank status sets on the clock edge at which `pix_x` is 0 and `pix_y` equals the active height. `vblank_irq` is status AND interrupt enable (address 7 bit 0).
- R11: A write to address 7 with bit 1 at 0 clears the status, and a write with bit 1 at 1 leaves it as it is. A set in the same cycle as a clear wins.
- R12: Writes to addresses 1 to 4 while running take effect at the edge where the counters wrap from the last pixel of the frame. While stopped they take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| hsync_o | output | 1 | Horizontal sync at programmed polarity |
| vsync_o | output | 1 | Vertical sync at programmed polarity |
| de_o | output | 1 | Data-enable, active region |
| hsync_oe | output | 1 | Output enable for hsync pin |
| vsync_oe | output | 1 | Output enable for vsync pin |
| de_oe | output | 1 | Output enable for data-enable pin |
| pix_x | output | 12 | Current pixel column |
| pix_y | output | 12 | Current line |
| vblank_irq | output | 1 | Vertical-blank interrupt request |

## Verification
The bench targets the back-porch convention. A design that measured the back porch from the end of the sync pulse would place hsync and vsync exactly one sync width too early. It also rewrites the line length in the middle of a frame. A design without the staging copy would let `pix_x` run past the old total inside the current frame. It checks when the interrupt status rises, expecting it in the second cycle of the first blank line. It also acknowledges with bit 1 both clear and set, which separates a real write-zero-to-clear from a clear on any write. Finally it flips polarity and partly masks the pins while running, and drops only one of the two enables, to show that one enable alone never starts the counters.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int CW      = 12;
    localparam int HI_LSB  = 16;
    localparam int ADDR_W  = 3;
    localparam int PIN_N   = 3;

    typedef logic [CW-1:0] crd_t;

    typedef struct packed {
        crd_t act_w;
        crd_t act_h;
        crd_t h_tot;
        crd_t h_bp;
        crd_t v_tot;
        crd_t v_bp;
        crd_t h_sw;
        crd_t v_sw;
    } tcfg_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_SIZE = 3'd1,
        RA_HTIM = 3'd2,
        RA_VTIM = 3'd3,
        RA_SYNC = 3'd4,
        RA_POL  = 3'd5,
        RA_TRI  = 3'd6,
        RA_IRQ  = 3'd7
    } raddr_e;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic              frame_end_i,
    input  logic              vbl_hit_i,
    output logic              run_o,
    output tcfg_t             cfg_o,
    output logic [1:0]        pol_o,
    output logic [PIN_N-1:0]  tri_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [1:0]       ctrl;
        tcfg_t            stage;
        tcfg_t            act;
        logic [1:0]       pol;
        logic [PIN_N-1:0] trim;
        logic             irq_en;
        logic             vbl_st;
    } rstate_t;

    rstate_t s_d, s_q;
    crd_t    lo_d, hi_d;
    logic    clr_d;
    logic    run_q;
    logic    unused_wbits;

    assign lo_d         = wr_data[CW-1:0];
    assign hi_d         = wr_data[HI_LSB+CW-1:HI_LSB];
    assign unused_wbits = ^{wr_data[DW-1:HI_LSB+CW], wr_data[HI_LSB-1:CW]};
    assign run_q        = &s_q.ctrl;

    always_comb begin
        s_d   = s_q;
        clr_d = 1'b0;
        if (!run_q || frame_end_i) begin
            s_d.act = s_q.stage;
        end
        if (wr_en) begin
            case (raddr_e'(addr))
                RA_CTRL: s_d.ctrl = wr_data[1:0];
                RA_SIZE: begin s_d.stage.act_w = lo_d; s_d.stage.act_h = hi_d; end
                RA_HTIM: begin s_d.stage.h_tot = lo_d; s_d.stage.h_bp  = hi_d; end
                RA_VTIM: begin s_d.stage.v_tot = lo_d; s_d.stage.v_bp  = hi_d; end
                RA_SYNC: begin s_d.stage.h_sw  = lo_d; s_d.stage.v_sw  = hi_d; end
                RA_POL:  s_d.pol  = wr_data[1:0];
                RA_TRI:  s_d.trim = wr_data[PIN_N-1:0];
                RA_IRQ:  begin s_d.irq_en = wr_data[0]; clr_d = ~wr_data[1]; end
                default: ;
            endcase
        end
        s_d.vbl_st = (s_q.vbl_st & ~clr_d) | vbl_hit_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ctrl: '0, stage: '0, act: '0, pol: '0,
                     trim: '1, irq_en: 1'b0, vbl_st: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (raddr_e'(addr))
            RA_CTRL: rd_data[1:0] = s_q.ctrl;
            RA_SIZE: begin rd_data[CW-1:0] = s_q.stage.act_w; rd_data[HI_LSB+CW-1:HI_LSB] = s_q.stage.act_h; end
            RA_HTIM: begin rd_data[CW-1:0] = s_q.stage.h_tot; rd_data[HI_LSB+CW-1:HI_LSB] = s_q.stage.h_bp;  end
            RA_VTIM: begin rd_data[CW-1:0] = s_q.stage.v_tot; rd_data[HI_LSB+CW-1:HI_LSB] = s_q.stage.v_bp;  end
            RA_SYNC: begin rd_data[CW-1:0] = s_q.stage.h_sw;  rd_data[HI_LSB+CW-1:HI_LSB] = s_q.stage.v_sw;  end
            RA_POL:  rd_data[1:0] = s_q.pol;
            RA_TRI:  rd_data[PIN_N-1:0] = s_q.trim;
            RA_IRQ:  rd_data[1:0] = {s_q.vbl_st, s_q.irq_en};
            default: ;
        endcase
    end

    assign run_o = run_q;
    assign cfg_o = s_q.act;
    assign pol_o = s_q.pol;
    assign tri_o = s_q.trim;
    assign irq_o = s_q.vbl_st & s_q.irq_en;

    AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_hit_i |=> s_q.vbl_st); // R10
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.vbl_st && !(wr_en && addr == RA_IRQ && !wr_data[1])) |=> s_q.vbl_st); // R11
    AST_CFG_NO_TEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !frame_end_i) |=> $stable(s_q.act)); // R12
endmodule

// File: rtl/ptg_scan.sv
module ptg_scan
    import ptg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  crd_t h_tot_i,
    input  crd_t v_tot_i,
    input  crd_t act_h_i,
    output crd_t x_o,
    output crd_t y_o,
    output logic frame_end_o,
    output logic vbl_hit_o
);
    typedef struct packed {
        crd_t x;
        crd_t y;
    } scan_t;

    scan_t c_d, c_q;
    logic  line_end;

    assign line_end = (c_q.x == h_tot_i - 1'b1);

    always_comb begin
        c_d = c_q;
        if (!run_i) begin
            c_d = '0;
        end else if (line_end) begin
            c_d.x = '0;
            c_d.y = (c_q.y == v_tot_i - 1'b1) ? '0 : c_q.y + 1'b1;
        end else begin
            c_d.x = c_q.x + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign x_o         = c_q.x;
    assign y_o         = c_q.y;
    assign frame_end_o = run_i && line_end && (c_q.y == v_tot_i - 1'b1);
    assign vbl_hit_o   = run_i && (c_q.x == '0) && (c_q.y == act_h_i);

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (c_q.x == '0 && c_q.y == '0)); // R3
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !line_end) |=> (c_q.x == $past(c_q.x) + 1'b1)); // R4
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (c_q.x == '0 && c_q.y == '0)); // R4
endmodule

// File: rtl/ptg_pins.sv
module ptg_pins
    import ptg_pkg::*;
(
    input  logic             run_i,
    input  tcfg_t            cfg_i,
    input  crd_t             x_i,
    input  crd_t             y_i,
    input  logic [1:0]       pol_i,
    input  logic [PIN_N-1:0] tri_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [PIN_N-1:0] oe_o
);
    crd_t        hs_start, vs_start;
    logic [CW:0] hs_stop, vs_stop;
    logic        hs_act, vs_act;

    always_comb begin
        hs_start = cfg_i.h_tot - cfg_i.h_bp;
        vs_start = cfg_i.v_tot - cfg_i.v_bp;
        hs_stop  = {1'b0, hs_start} + {1'b0, cfg_i.h_sw};
        vs_stop  = {1'b0, vs_start} + {1'b0, cfg_i.v_sw};
        hs_act   = run_i && (x_i >= hs_start) && ({1'b0, x_i} < hs_stop);
        vs_act   = run_i && (y_i >= vs_start) && ({1'b0, y_i} < vs_stop);
        hsync_o  = hs_act ~^ pol_i[0];
        vsync_o  = vs_act ~^ pol_i[1];
        de_o     = run_i && (x_i < cfg_i.act_w) && (y_i < cfg_i.act_h);
        oe_o     = ~tri_i;
    end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import ptg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              hsync_oe,
    output logic              vsync_oe,
    output logic              de_oe,
    output logic [CW-1:0]     pix_x,
    output logic [CW-1:0]     pix_y,
    output logic              vblank_irq
);
    logic             run, frame_end, vbl_hit;
    tcfg_t            cfg;
    logic [1:0]       pol;
    logic [PIN_N-1:0] trim, oe;
    crd_t             x, y;

    ptg_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .frame_end_i(frame_end),
        .vbl_hit_i(vbl_hit), .run_o(run), .cfg_o(cfg), .pol_o(pol),
        .tri_o(trim), .irq_o(vblank_irq)
    );

    ptg_scan u_scan (
        .clk(clk), .rst_n(rst_n), .run_i(run), .h_tot_i(cfg.h_tot),
        .v_tot_i(cfg.v_tot), .act_h_i(cfg.act_h), .x_o(x), .y_o(y),
        .frame_end_o(frame_end), .vbl_hit_o(vbl_hit)
    );

    ptg_pins u_pins (
        .run_i(run), .cfg_i(cfg), .x_i(x), .y_i(y), .pol_i(pol),
        .tri_i(trim), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .oe_o(oe)
    );

    assign hsync_oe = oe[0];
    assign vsync_oe = oe[1];
    assign de_oe    = oe[2];
    assign pix_x    = x;
    assign pix_y    = y;
endmodule

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync_o, vsync_o, de_o, hsync_oe, vsync_oe, de_oe, vblank_irq;
    logic [11:0] pix_x, pix_y;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_ctrl, m_pol, m_tri, m_en, m_st, m_x, m_y;
    int sg[8];
    int ac[8];   // 0 w,1 h,2 htot,3 hbp,4 vtot,5 vbp,6 hsw,7 vsw

    lcd_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .hsync_oe(hsync_oe),
        .vsync_oe(vsync_oe), .de_oe(de_oe), .pix_x(pix_x), .pix_y(pix_y),
        .vblank_irq(vblank_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_pol = 0; m_tri = 7; m_en = 0; m_st = 0; m_x = 0; m_y = 0;
            for (int i = 0; i < 8; i++) begin sg[i] = 0; ac[i] = 0; end
        end else begin
            bit run, fe, hit, clr;
            run = (m_ctrl == 3);
            fe  = run && m_x == ac[2] - 1 && m_y == ac[4] - 1;
            hit = run && m_x == 0 && m_y == ac[1];
            clr = 0;
            if (!run) begin
                m_x = 0; m_y = 0;
            end else if (m_x == ac[2] - 1) begin
                m_x = 0;
                m_y = (m_y == ac[4] - 1) ? 0 : m_y + 1;
            end else begin
                m_x = m_x + 1;
            end
            if (!run || fe) for (int i = 0; i < 8; i++) ac[i] = sg[i];
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_ctrl = int'(reg_wdata[1:0]);
                    3'd1, 3'd2, 3'd3, 3'd4: begin
                        sg[2*(reg_addr-1)]   = int'(reg_wdata[11:0]);
                        sg[2*(reg_addr-1)+1] = int'(reg_wdata[27:16]);
                    end
                    3'd5: m_pol = int'(reg_wdata[1:0]);
                    3'd6: m_tri = int'(reg_wdata[2:0]);
                    default: begin m_en = int'(reg_wdata[0]); clr = !reg_wdata[1]; end
                endcase
            end
            m_st = ((m_st != 0) && !clr) || hit ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit run, ha, va;
            int hs0, vs0;
            run = (m_ctrl == 3);
            hs0 = ac[2] - ac[3];
            vs0 = ac[4] - ac[5];
            ha  = run && m_x >= hs0 && m_x < hs0 + ac[6];
            va  = run && m_y >= vs0 && m_y < vs0 + ac[7];
            check("R4", "pix_x", int'(pix_x), m_x);
            check("R4", "pix_y", int'(pix_y), m_y);
            check("R5", "hsync", int'(hsync_o), (m_pol & 1) ? int'(ha) : int'(!ha));
            check("R6", "vsync", int'(vsync_o), (m_pol & 2) ? int'(va) : int'(!va));
            check("R8", "de", int'(de_o), int'(run && m_x < ac[0] && m_y < ac[1]));
            check("R9", "oe", int'({de_oe, vsync_oe, hsync_oe}), (~m_tri) & 7);
            check("R10", "irq", int'(vblank_irq), m_st & m_en);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int pk(int lo, int hi);
        return (hi << 16) | lo;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6, v); check("R1", "tri mask", v, 7);
        rd(0, v); check("R1", "ctrl", v, 0);
        check("R1", "oe", int'({de_oe, vsync_oe, hsync_oe}), 0);
        check("R1", "irq", int'(vblank_irq), 0);
        check("R1", "pix_x", int'(pix_x), 0);

        // programming: w6 h4, htot10 hbp3, vtot7 vbp2, hsw2 vsw1
        wr(1, pk(6, 4)); wr(2, pk(10, 3)); wr(3, pk(7, 2)); wr(4, pk(2, 1));
        rd(2, v); check("R2", "line timing readback", v, pk(10, 3));
        rd(4, v); check("R2", "sync readback", v, pk(2, 1));
        wr(5, 0); wr(6, 0); wr(7, 1);
        rd(7, v); check("R2", "irq readback", v, 1);

        // R3 one enable only
        wr(0, 1);
        repeat (5) @(negedge clk);
        check("R3", "x held (global only)", int'(pix_x), 0);
        check("R3", "hsync idle low-active", int'(hsync_o), 1);
        check("R3", "de low", int'(de_o), 0);

        wr(0, 3);
        // R4 wrap
        while (pix_x != 12'd9) @(negedge clk);
        @(negedge clk);
        check("R4", "x wraps after total-1", int'(pix_x), 0);

        // R10 set timing
        for (int i = 0; i < 200 && !vblank_irq; i++) @(negedge clk);
        check("R10", "irq line", int'(pix_y), 4);
        check("R10", "irq column", int'(pix_x), 1);
        // R11 ack with bit1=1 keeps, with bit1=0 clears
        wr(7, 3);
        check("R11", "status kept on bit1=1", int'(vblank_irq), 1);
        wr(7, 1);
        check("R11", "status cleared", int'(vblank_irq), 0);

        // R12 mid-frame change of line length
        while (pix_y != 12'd1) @(negedge clk);
        wr(2, pk(12, 3));
        for (int i = 0; i < 100 && !(pix_x == 0 && pix_y == 0); i++) begin
            @(negedge clk);
            if (pix_x >= 12'd10) check("R12", "old total kept in frame", int'(pix_x), 9);
        end
        repeat (11) @(negedge clk);
        check("R12", "new total after wrap", int'(pix_x), 11);

        // R7 polarity flip and partial masking while running
        wr(5, 3); wr(6, 5);
        repeat (180) @(negedge clk);
        wr(0, 2);
        @(negedge clk);
        check("R7", "hsync idle for active-high", int'(hsync_o), 0);
        check("R7", "vsync idle for active-high", int'(vsync_o), 0);
        check("R3", "x held (channel only)", int'(pix_x), 0);
        check("R9", "vsync oe only", int'({de_oe, vsync_oe, hsync_oe}), 2);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule